// File: doc/BRIEF.md
# Persistent Request Table with Fixed-Priority Arbitration

Each cache in a token-counting multiprocessor keeps one copy of this table. Processors that fail to collect tokens with ordinary requests broadcast a heavyweight "start" message naming a block address and whether they want to read or write. When they are done, they broadcast a "stop" message. Every copy of the table sees the same ordered stream of these messages. Each copy therefore reaches the same decision on its own, with no central arbiter. A handoff between requesters costs a single message latency.

The table holds one slot per processor, selected by processor number. Each slot carries a valid flag, a block address and a read/write flag. For every incoming coherence message, the cache presents the block address as a lookup key. The table searches all slots by address. One cycle later it reports whether a persistent requester exists and which one has priority: the lowest processor number wins. It also reports whether that requester wants to read. If so, the cache keeps one token when it holds more than one; otherwise it forwards all of them.

The table also enforces a wave rule on the processor attached to this cache. After that processor stops, it must stay out while other requesters for the same block remain. It may issue again only once the address has no valid slot left.

Top module: `prt_table`

## Requirements
- R1: After synchronous reset, `lk_hit`, `lk_winner`, `lk_rd` and `loc_wait` are 0 and every slot is empty, so a lookup misses.
- R2: A start message (`msg_vld`=1, `msg_act`=1) fills slot `msg_src` with `msg_addr` and `msg_rd`. A lookup for that address presented in the same cycle or later returns `lk_hit`=1 and `lk_winner`=`msg_src` on the next cycle.
- R3: A lookup whose address matches no valid slot returns `lk_hit`=0, `lk_winner`=0 and `lk_rd`=0 on the next cycle.
- R4: When several valid slots hold the lookup address, `lk_winner` is the lowest processor number among them.
- R5: A stop message (`msg_vld`=1, `msg_act`=0) empties slot `msg_src`. A lookup presented in the same cycle as the stop already excludes that slot.
- R6: Valid slots holding other addresses do not affect a lookup's result.
- R7: Each processor owns exactly one slot. A new start from a processor replaces its earlier address and flag.
- R8: `lk_rd` is the read/write flag of the winning slot: 1 means read, 0 means write.
- R9: A stop from processor `LOCAL_ID` sets `loc_wait`=1 on the next cycle if another valid slot still holds the same address. `loc_wait` returns to 0 on the cycle after the last such slot is emptied. A stop with no such slot leaves `loc_wait` at 0.
- R10: Lookup results are registered. A cycle with `lk_vld`=0 yields `lk_hit`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_vld | input | 1 | Persistent message present this cycle |
| msg_act | input | 1 | 1 = start, 0 = stop |
| msg_src | input | PW | Sending processor number |
| msg_addr | input | AW | Block address of a start |
| msg_rd | input | 1 | 1 = read request, 0 = write request |
| lk_vld | input | 1 | Lookup key present this cycle |
| lk_addr | input | AW | Lookup block address |
| lk_hit | output | 1 | A persistent requester exists for the key |
| lk_winner | output | PW | Highest-priority requester for the key |
| lk_rd | output | 1 | Winner wants to read |
| loc_wait | output | 1 | Local processor must wait for the next wave |

## Verification
The bench sends a start together with a lookup of the same address in one cycle. A table that did not bypass the pending update would miss. It also sends a stop alongside a lookup of the same address. A design applying the stop a cycle late would still name the departing processor. It stacks several requesters on one address, which catches a design that picks the highest index or the most recent arrival, or that lets a slot for another address leak in. A processor is moved to a new address, which exposes a table that keeps a stale copy. The wave tests hold the local stop while one requester remains, pass an unrelated start in between, and then empty the address. A design that ended the wave early, never ended it, or marked a lone stop would show the wrong `loc_wait`.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic {
    MSG_STOP  = 1'b0,
    MSG_START = 1'b1
  } prt_kind_e;
endpackage

// File: rtl/prt_store.sv
module prt_store
  import prt_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int AW    = 16,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      msg_vld,
  input  logic                      msg_act,
  input  logic [PW-1:0]             msg_src,
  input  logic [AW-1:0]             msg_addr,
  input  logic                      msg_rd,
  output logic [NPROC-1:0]          valid_nx,
  output logic [NPROC-1:0][AW-1:0]  addr_nx,
  output logic [NPROC-1:0]          rd_nx
);
  logic [NPROC-1:0]         valid_q;
  logic [NPROC-1:0][AW-1:0] addr_q;
  logic [NPROC-1:0]         rd_q;

  for (genvar i = 0; i < NPROC; i++) begin : g_slot
    logic sel;
    assign sel = msg_vld && (msg_src == PW'(i));
    always_comb begin
      valid_nx[i] = valid_q[i];
      addr_nx[i]  = addr_q[i];
      rd_nx[i]    = rd_q[i];
      if (sel) begin
        valid_nx[i] = (prt_kind_e'(msg_act) == MSG_START);
        if (prt_kind_e'(msg_act) == MSG_START) begin
          addr_nx[i] = msg_addr;
          rd_nx[i]   = msg_rd;
        end
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        addr_q[i]  <= '0;
        rd_q[i]    <= 1'b0;
      end else begin
        valid_q[i] <= valid_nx[i];
        addr_q[i]  <= addr_nx[i];
        rd_q[i]    <= rd_nx[i];
      end
    end
  end

  // R2: a start fills the sender's slot
  a_r2_start_fills: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && msg_act) |=> (valid_q[$past(msg_src)] && addr_q[$past(msg_src)] == $past(msg_addr)));

  // R5: a stop empties the sender's slot
  a_r5_stop_empties: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && !msg_act) |=> !valid_q[$past(msg_src)]);
endmodule

// File: rtl/prt_cam.sv
module prt_cam #(
  parameter int NPROC = 4,
  parameter int AW    = 16
) (
  input  logic [NPROC-1:0]          valid,
  input  logic [NPROC-1:0][AW-1:0]  addr,
  input  logic [AW-1:0]             key,
  output logic [NPROC-1:0]          match
);
  for (genvar i = 0; i < NPROC; i++) begin : g_cmp
    assign match[i] = valid[i] && (addr[i] == key);
  end
endmodule

// File: rtl/prt_pick.sv
module prt_pick #(
  parameter int NPROC = 4,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NPROC-1:0] req,
  output logic             any,
  output logic [PW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (req[i]) idx = PW'(i);
    end
  end
  assign any = |req;

  // R4: no lower-numbered requester exists below the chosen one
  always_comb begin
    if (any) a_r4_lowest_wins: assert ((req & ((NPROC'(1) << idx) - NPROC'(1))) == '0 && req[idx]);
  end
endmodule

// File: rtl/prt_table.sv
module prt_table
  import prt_pkg::*;
#(
  parameter int NPROC    = 4,
  parameter int AW       = 16,
  parameter int LOCAL_ID = 0,
  localparam int PW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msg_vld,
  input  logic          msg_act,
  input  logic [PW-1:0] msg_src,
  input  logic [AW-1:0] msg_addr,
  input  logic          msg_rd,
  input  logic          lk_vld,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [PW-1:0] lk_winner,
  output logic          lk_rd,
  output logic          loc_wait
);
  logic [NPROC-1:0]         valid_nx;
  logic [NPROC-1:0][AW-1:0] addr_nx;
  logic [NPROC-1:0]         rd_nx;
  logic [NPROC-1:0]         lk_match, wave_match;
  logic                     pick_any;
  logic [PW-1:0]            pick_idx;
  logic                     from_local, wave_d;

  prt_store #(.NPROC(NPROC), .AW(AW)) store_i (
    .clk(clk), .rst(rst), .msg_vld(msg_vld), .msg_act(msg_act),
    .msg_src(msg_src), .msg_addr(msg_addr), .msg_rd(msg_rd),
    .valid_nx(valid_nx), .addr_nx(addr_nx), .rd_nx(rd_nx)
  );

  prt_cam #(.NPROC(NPROC), .AW(AW)) lk_cam_i (
    .valid(valid_nx), .addr(addr_nx), .key(lk_addr), .match(lk_match)
  );

  prt_cam #(.NPROC(NPROC), .AW(AW)) wave_cam_i (
    .valid(valid_nx), .addr(addr_nx), .key(addr_nx[LOCAL_ID]), .match(wave_match)
  );

  prt_pick #(.NPROC(NPROC)) pick_i (
    .req(lk_match), .any(pick_any), .idx(pick_idx)
  );

  assign from_local = msg_vld && (msg_src == PW'(LOCAL_ID));
  assign wave_d = ((from_local && prt_kind_e'(msg_act) == MSG_STOP) || loc_wait)
                  && !(from_local && prt_kind_e'(msg_act) == MSG_START)
                  && (|wave_match);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_winner <= '0;
      lk_rd     <= 1'b0;
      loc_wait  <= 1'b0;
    end else begin
      lk_hit    <= lk_vld && pick_any;
      lk_winner <= (lk_vld && pick_any) ? pick_idx : '0;
      lk_rd     <= (lk_vld && pick_any) ? rd_nx[pick_idx] : 1'b0;
      loc_wait  <= wave_d;
    end
  end

  // R10: an idle lookup cycle gives no hit
  a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !lk_vld |=> !lk_hit);

  // R9: the wait flag only starts on a stop from the local processor
  a_r9_wait_starts_on_stop: assert property (@(posedge clk) disable iff (rst)
    (!loc_wait && !(from_local && !msg_act)) |=> !loc_wait);

  // R3: a miss reports processor 0 and write
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_winner == '0 && !lk_rd));
endmodule

// File: tb/prt_table_tb_top.sv
module prt_table_tb_top;
  localparam int NPROC = 4;
  localparam int AW    = 16;
  localparam int PW    = 2;
  localparam int LOC   = 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          msg_vld, msg_act, msg_rd, lk_vld;
  logic [PW-1:0] msg_src;
  logic [AW-1:0] msg_addr, lk_addr;
  logic          lk_hit, lk_rd, loc_wait;
  logic [PW-1:0] lk_winner;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prt_table #(.NPROC(NPROC), .AW(AW), .LOCAL_ID(LOC)) dut_i (
    .clk(clk), .rst(rst), .msg_vld(msg_vld), .msg_act(msg_act),
    .msg_src(msg_src), .msg_addr(msg_addr), .msg_rd(msg_rd),
    .lk_vld(lk_vld), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_winner(lk_winner), .lk_rd(lk_rd), .loc_wait(loc_wait)
  );

  localparam logic [AW-1:0] A = 16'h1000, B = 16'h2000, C = 16'h3000,
                            D = 16'h4000, E = 16'h5000;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample just after the next posedge
  task automatic cyc(input logic mv, input logic ma, input int ms,
                     input logic [AW-1:0] maddr, input logic mrd,
                     input logic lv, input logic [AW-1:0] laddr);
    @(negedge clk);
    msg_vld = mv; msg_act = ma; msg_src = PW'(ms); msg_addr = maddr;
    msg_rd = mrd; lk_vld = lv; lk_addr = laddr;
    @(posedge clk); #1;
    msg_vld = 1'b0; lk_vld = 1'b0;
  endtask

  task automatic start(input int s, input logic [AW-1:0] a, input logic r);
    cyc(1'b1, 1'b1, s, a, r, 1'b0, '0);
  endtask
  task automatic stop(input int s);
    cyc(1'b1, 1'b0, s, '0, 1'b0, 1'b0, '0);
  endtask
  task automatic look(input logic [AW-1:0] a);
    cyc(1'b0, 1'b0, 0, '0, 1'b0, 1'b1, a);
  endtask

  task automatic t_reset;
    check("R1 hit after reset", lk_hit, 0);
    check("R1 wait after reset", loc_wait, 0);
    look(A);
    check("R1 empty table miss", lk_hit, 0);
  endtask

  task automatic t_single;
    cyc(1'b1, 1'b1, 2, A, 1'b1, 1'b1, A);
    check("R2 same-cycle hit", lk_hit, 1);
    check("R2 winner", lk_winner, 2);
    check("R8 read flag", lk_rd, 1);
  endtask

  task automatic t_prio;
    start(3, A, 1'b0);
    look(A);
    check("R4 winner of 2,3", lk_winner, 2);
    start(0, A, 1'b0);
    look(A);
    check("R4 winner of 0,2,3", lk_winner, 0);
    check("R8 write flag", lk_rd, 0);
  endtask

  task automatic t_cam;
    look(B);
    check("R3 miss hit", lk_hit, 0);
    check("R3 miss winner", lk_winner, 0);
    check("R3 miss rd", lk_rd, 0);
    start(1, B, 1'b1);
    look(B);
    check("R6 B winner", lk_winner, 1);
    look(A);
    check("R6 A unaffected", lk_winner, 0);
  endtask

  task automatic t_stop;
    cyc(1'b1, 1'b0, 0, '0, 1'b0, 1'b1, A);
    check("R5 same-cycle stop hit", lk_hit, 1);
    check("R5 same-cycle stop winner", lk_winner, 2);
  endtask

  task automatic t_move;
    start(3, B, 1'b0);
    look(A);
    check("R7 A after move", lk_winner, 2);
    stop(1);
    look(B);
    check("R7 B winner after move", lk_winner, 3);
    check("R7 B flag replaced", lk_rd, 0);
    stop(2); stop(3);
    look(A);
    check("R5 A empty", lk_hit, 0);
  endtask

  task automatic t_idle;
    start(2, A, 1'b1);
    cyc(1'b0, 1'b0, 0, '0, 1'b0, 1'b0, A);
    check("R10 idle lookup", lk_hit, 0);
    stop(2);
  endtask

  task automatic t_wave;
    start(LOC, C, 1'b1);
    start(2, C, 1'b0);
    look(C);
    check("R4 local wins C", lk_winner, LOC);
    cyc(1'b1, 1'b0, LOC, '0, 1'b0, 1'b1, C);
    check("R9 wait set", loc_wait, 1);
    check("R5 next requester", lk_winner, 2);
    start(3, E, 1'b0);
    check("R9 wait held", loc_wait, 1);
    look(C);
    check("R9 wait held idle", loc_wait, 1);
    stop(2);
    check("R9 wait ends with wave", loc_wait, 0);
    stop(3);
    start(LOC, D, 1'b0);
    stop(LOC);
    check("R9 lone stop no wait", loc_wait, 0);
  endtask

  initial begin
    rst = 1'b1; msg_vld = 1'b0; msg_act = 1'b0; msg_src = '0; msg_addr = '0;
    msg_rd = 1'b0; lk_vld = 1'b0; lk_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_single;
    t_prio;
    t_cam;
    t_stop;
    t_move;
    t_idle;
    t_wave;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule